// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external byte-wide asynchronous static RAM with 17 address bits. The host hands over one request at a time on a valid/ready channel carrying the address, the write data and a read/write flag. The controller then drives the RAM's address, its active-low and active-high select pins, its write strobe and its output-enable strobe. It shapes each bus phase with a wait-state counter, so every phase lasts long enough to meet the RAM's minimum access, pulse, setup and bus-float times.

All minimum times are parameters in nanoseconds, next to a parameter giving the clock period. Each time is turned into a whole number of cycles by rounding up, with at least one cycle per phase. The data bus is split into an output byte, an output-enable and an input byte, so the pad ring can build the tri-state pin. Read results come back on a response strobe that the host cannot stall. The host must be able to take one byte in any cycle. Back-pressure exists only on the request side: the host holds a request, unchanged, until it sees ready high at a clock edge. Writes produce no response. The host knows a write is done when ready returns high.

Top module: `sram_async_ctrl`

## Requirements
- R1: Out of reset and whenever ready is high, the controller holds both select pins inactive (active-low select high, active-high select low), holds the write and output-enable strobes high, and keeps its data drivers off.
- R2: A request is taken only at a clock edge where both valid and ready are high. Ready then stays low until the access has finished, and a request held with valid while ready is low is not taken early.
- R3: A read selects the RAM and lowers output-enable, with the write strobe high and the address steady, for N_RD cycles. N_RD is the larger of ceil(access time / period) and ceil(output-enable access / period), and at least 1. This gives 3 cycles at 20 ns.
- R4: Each read gives exactly one response pulse, one cycle long, in the cycle after the read window. The response carries the data bus value sampled at the last edge of the window. A write gives no response.
- R5: After a read, output-enable and the selects are released. The controller then waits N_TURN = ceil(bus float time / period) cycles, at least 1 (1 at 20 ns), with ready low and its drivers off.
- R6: A write starts with one setup cycle: RAM selected, write strobe and output-enable high, address and write data presented, data drivers on.
- R7: The write strobe is then held low for N_WP cycles. N_WP is the largest of ceil(pulse width / period), ceil(data setup / period) and ceil(write cycle / period) minus 2, and at least 1. This gives 3 cycles at 20 ns.
- R8: After the write strobe rises, one hold cycle follows with the RAM still selected and the address and data unchanged. Address and data never change while the write strobe is low. The stored byte is the one requested.
- R9: The controller's data drivers are never on while output-enable is low, and the write strobe is low only while output-enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_data | output | 8 | Read byte |
| ram_addr | output | 17 | RAM address pins |
| ram_dq_o | output | 8 | Data driven towards the RAM |
| ram_dq_oe | output | 1 | Enable for the data pad drivers |
| ram_dq_i | input | 8 | Data seen on the RAM data pins |
| ram_sel_n | output | 1 | Active-low RAM select |
| ram_sel | output | 1 | Active-high RAM select |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |

## Verification
The hardest case to reach from the ports is a host that never drops valid. In that case each new request waits for the last cycle of the previous phase, and the accept edge coincides with the write hold or the read turnaround ending. The bench reaches it by calling its request task back to back, so valid stays high across accesses. The cycle model in the bench then shows whether a request is taken one cycle early or late. A behavioural RAM on the pins flags any cycle where both sides drive the bus. It also stores bytes only on a write strobe rising edge, so a short pulse, a moving address or a skipped hold cycle appears as wrong data on the next read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_TURN,
    PH_WSETUP,
    PH_WPULSE,
    PH_WHOLD
  } phase_e;

  // Minimum time in ns -> whole cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned per_ns);
    int unsigned c;
    c = (t_ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_port.sv
module sram_dq_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drive_d,
  input  logic              wdata_load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_o      <= '0;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      dq_oe     <= drive_d;
      rsp_valid <= capture;
      if (wdata_load) dq_o <= wdata;
      if (capture)    rsp_data <= dq_i;
    end
  end

  // R4: a response never spans two cycles
  assert_rsp_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid)
    else $error("response strobe longer than one cycle");

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int CLK_NS      = 20,
  parameter int T_ACC_NS    = 55,
  parameter int T_OE_NS     = 20,
  parameter int T_FLOAT_NS  = 20,
  parameter int T_WP_NS     = 45,
  parameter int T_DS_NS     = 25,
  parameter int T_WC_NS     = 55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [DATA_W-1:0] ram_dq_i,
  output logic              ram_sel_n,
  output logic              ram_sel,
  output logic              ram_we_n,
  output logic              ram_oe_n
);

  localparam int unsigned N_RD   = umax(ns_to_cyc(T_ACC_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int unsigned N_TURN = ns_to_cyc(T_FLOAT_NS, CLK_NS);
  localparam int unsigned N_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int unsigned N_WP   = umax(umax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DS_NS, CLK_NS)),
                                        (N_WC > 2) ? N_WC - 2 : 1);
  localparam int unsigned N_MAX  = umax(umax(N_RD, N_TURN), N_WP);
  localparam int          CNT_W  = (N_MAX < 2) ? 1 : $clog2(N_MAX);

  phase_e           state_q, state_d;
  logic             tmr_load, tmr_expired, capture, accept;
  logic [CNT_W-1:0] tmr_val;
  logic             sel_d, drive_d;

  sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign accept = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    case (state_q)
      PH_IDLE: begin
        if (accept) begin
          if (req_write) begin
            state_d = PH_WSETUP;
          end else begin
            state_d  = PH_READ;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(N_RD - 1);
          end
        end
      end
      PH_READ: begin
        if (tmr_expired) begin
          capture  = 1'b1;
          state_d  = PH_TURN;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(N_TURN - 1);
        end
      end
      PH_TURN:   if (tmr_expired) state_d = PH_IDLE;
      PH_WSETUP: begin
        state_d  = PH_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(N_WP - 1);
      end
      PH_WPULSE: if (tmr_expired) state_d = PH_WHOLD;
      PH_WHOLD:  state_d = PH_IDLE;
      default:   state_d = PH_IDLE;
    endcase
  end

  assign sel_d   = (state_d == PH_READ) || (state_d == PH_WSETUP) ||
                   (state_d == PH_WPULSE) || (state_d == PH_WHOLD);
  assign drive_d = (state_d == PH_WSETUP) || (state_d == PH_WPULSE) || (state_d == PH_WHOLD);

  // Pin registers follow the next phase so the pins are glitch-free.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PH_IDLE;
      req_ready <= 1'b1;
      ram_addr  <= '0;
      ram_sel_n <= 1'b1;
      ram_sel   <= 1'b0;
      ram_we_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
    end else begin
      state_q   <= state_d;
      req_ready <= (state_d == PH_IDLE);
      ram_sel_n <= !sel_d;
      ram_sel   <= sel_d;
      ram_we_n  <= (state_d != PH_WPULSE);
      ram_oe_n  <= (state_d != PH_READ);
      if (accept) ram_addr <= req_addr;
    end
  end

  sram_dq_port #(.DATA_W(DATA_W)) u_dq (
    .clk        (clk),
    .rst_n      (rst_n),
    .drive_d    (drive_d),
    .wdata_load (accept && req_write),
    .wdata      (req_wdata),
    .capture    (capture),
    .dq_i       (ram_dq_i),
    .dq_o       (ram_dq_o),
    .dq_oe      (ram_dq_oe),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  // Checker-only count of write-strobe low cycles.
  logic [CNT_W:0] wlow_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wlow_cnt <= '0;
    else if (!ram_we_n) wlow_cnt <= wlow_cnt + 1'b1;
    else                wlow_cnt <= '0;
  end

  assert_idle_safe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_sel_n && !ram_sel && ram_we_n && ram_oe_n && !ram_dq_oe))
    else $error("pins not parked while ready");

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready)
    else $error("ready stayed high after accept");

  assert_read_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> (!ram_sel_n && ram_sel && ram_we_n))
    else $error("output enable low without a clean read select");

  assert_read_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |=> (ram_oe_n || $stable(ram_addr)))
    else $error("address moved during read");

  assert_turn_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_oe_n) |-> !req_ready)
    else $error("no bus float gap after read");

  assert_setup_before_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> $past(ram_dq_oe && !ram_sel_n && ram_sel && ram_we_n))
    else $error("write strobe without a setup cycle");

  assert_strobe_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (wlow_cnt >= (CNT_W+1)'(N_WP)))
    else $error("write strobe too short");

  assert_write_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |=> ($stable(ram_addr) && $stable(ram_dq_o) && !ram_sel_n && ram_sel && ram_dq_oe))
    else $error("address or data unstable around write strobe");

  assert_no_contend_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> ram_oe_n)
    else $error("drivers on while RAM output enabled");

  assert_strobe_oe_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n)
    else $error("write strobe low with output enable low");

endmodule

// File: tb/tb_sram_async_ctrl.sv
`timescale 1ns/1ps
module tb_sram_async_ctrl;

  localparam int NRD = 3;   // R3 at 20 ns
  localparam int NTURN = 1; // R5
  localparam int NWP = 3;   // R7

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [16:0] ram_addr;
  logic [7:0]  ram_dq_o;
  logic        ram_dq_oe;
  logic [7:0]  ram_dq_i;
  logic        ram_sel_n, ram_sel, ram_we_n, ram_oe_n;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .ram_addr(ram_addr), .ram_dq_o(ram_dq_o), .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i),
    .ram_sel_n(ram_sel_n), .ram_sel(ram_sel), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n)
  );

  function automatic logic [7:0] fill(input logic [16:0] a);
    return a[7:0] ^ {1'b0, a[16:10]} ^ 8'h5A;
  endfunction

  // ---------------- behavioural RAM on the pins ----------------
  logic [7:0] ram_mem [int];
  logic       ram_drive;
  logic [7:0] ram_rd;

  always @(ram_addr or ram_oe_n or ram_sel_n or ram_sel or ram_we_n) begin
    ram_drive = (ram_sel_n === 1'b0) && (ram_sel === 1'b1) && (ram_oe_n === 1'b0) && (ram_we_n === 1'b1);
    ram_rd    = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : fill(ram_addr);
  end

  assign ram_dq_i = ram_dq_oe ? ram_dq_o : (ram_drive ? ram_rd : 8'hzz);

  always @(posedge ram_we_n)
    if (ram_sel_n === 1'b0 && ram_sel === 1'b1) ram_mem[int'(ram_addr)] = ram_dq_o;

  // ---------------- cycle reference model ----------------
  localparam int M_IDLE = 0, M_RD = 1, M_TURN = 2, M_WS = 3, M_WP = 4, M_WH = 5;
  int         m_phase = M_IDLE;
  int         m_left = 0;
  logic [16:0] m_addr = '0;
  logic [7:0]  m_data = '0;
  bit          m_rsp = 0;
  logic [7:0]  m_rdata = '0;
  logic [7:0]  shadow [int];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = M_IDLE; m_rsp = 0;
    end else begin
      m_rsp = 0;
      case (m_phase)
        M_IDLE: if (req_valid) begin
          m_addr = req_addr;
          if (req_write) begin
            m_data = req_wdata; shadow[int'(req_addr)] = req_wdata; m_phase = M_WS;
          end else begin
            m_phase = M_RD; m_left = NRD;
          end
        end
        M_RD: if (m_left == 1) begin
          m_rsp = 1;
          m_rdata = shadow.exists(int'(m_addr)) ? shadow[int'(m_addr)] : fill(m_addr);
          m_phase = M_TURN; m_left = NTURN;
        end else m_left--;
        M_TURN: if (m_left == 1) m_phase = M_IDLE; else m_left--;
        M_WS: begin m_phase = M_WP; m_left = NWP; end
        M_WP: if (m_left == 1) m_phase = M_WH; else m_left--;
        default: m_phase = M_IDLE;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      automatic bit   e_sel = (m_phase != M_IDLE) && (m_phase != M_TURN);
      automatic bit   e_oe_n = (m_phase != M_RD);
      automatic bit   e_we_n = (m_phase != M_WP);
      automatic bit   e_drv = (m_phase == M_WS) || (m_phase == M_WP) || (m_phase == M_WH);
      automatic string tag;
      case (m_phase)
        M_IDLE: tag = "R1";
        M_RD: tag = "R3";
        M_TURN: tag = "R5";
        M_WS: tag = "R6";
        M_WP: tag = "R7";
        default: tag = "R8";
      endcase
      chk(req_ready === (m_phase == M_IDLE), "R2", "ready", req_ready, m_phase == M_IDLE);
      chk(ram_sel_n === !e_sel, tag, "sel_n", ram_sel_n, !e_sel);
      chk(ram_sel === e_sel, tag, "sel", ram_sel, e_sel);
      chk(ram_oe_n === e_oe_n, tag, "oe_n", ram_oe_n, e_oe_n);
      chk(ram_we_n === e_we_n, tag, "we_n", ram_we_n, e_we_n);
      chk(ram_dq_oe === e_drv, tag, "dq_oe", ram_dq_oe, e_drv);
      if (e_sel) chk(ram_addr === m_addr, tag, "addr", ram_addr, m_addr);
      if (e_drv) chk(ram_dq_o === m_data, tag, "wdata", ram_dq_o, m_data);
      chk(rsp_valid === m_rsp, "R4", "rsp_valid", rsp_valid, m_rsp);
      if (m_rsp) chk(rsp_data === m_rdata, "R4", "rsp_data", rsp_data, m_rdata);
      chk(!(ram_dq_oe === 1'b1 && ram_drive), "R9", "contention", ram_dq_oe, 0);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input bit w, input logic [16:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      if (req_ready === 1'b1) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;            // R1 checked during and after reset
    idle(2);
    send(1, 17'h00000, 8'h11);   // R6 R7 R8
    send(1, 17'h1FFFF, 8'hEE);   // top address
    idle(2);
    send(0, 17'h00000, 8'h00);   // R3 R4 R5
    send(0, 17'h1FFFF, 8'h00);
    send(0, 17'h0ABCD, 8'h00);   // never written
    idle(3);
    send(1, 17'h00100, 8'hA5);   // read right after write
    send(0, 17'h00100, 8'h00);
    send(1, 17'h00100, 8'h00);   // write right after read
    send(0, 17'h00100, 8'h00);
    send(1, 17'h00000, 8'h00);   // overwrite
    send(0, 17'h00000, 8'h00);
    for (int i = 0; i < 20; i++) send(1, 17'((i * 4097) & 17'h1FFFF), 8'((i * 37) + 3));
    for (int i = 19; i >= 0; i--) send(0, 17'((i * 4097) & 17'h1FFFF), 8'h00);
    for (int i = 0; i < 8; i++) begin
      send(i[0], 17'(i * 3), 8'(i + 100));
      if (i == 4) idle(1);
    end
    for (int i = 0; i < 8; i++) send(0, 17'(i * 3), 8'h00);
    idle(8);
    finish_run();
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

endmodule